// File: doc/BRIEF.md
# Receive Frame Page Writer

This block takes one incoming Ethernet frame and lays it out in a packet page of the receive buffer RAM. A frame starts with a descriptor beat that gives the frame length. The bytes then follow one per handshake, and the last byte is flagged. The block decides at the descriptor whether the frame can be kept. If it can, it claims the offered page from the page allocator and writes the frame into that page one byte per cycle. The finished page holds a status word, a stored-length field, the payload padded to the minimum frame size, an optional CRC-32 and a two-byte trailer.

When a frame cannot be kept, its bytes are still taken from the stream so the source never stalls, but nothing is written. When a kept frame is complete, the block emits a one-cycle completion pulse carrying the page number. The surrounding controller uses this pulse to push the page onto its receive queue and to raise its receive interrupt. Only one frame is handled at a time: the descriptor input is not ready until the previous frame has been fully written or discarded.

Top module: `rxf_formatter`

## Requirements
- R1: After reset the block is idle: `frm_ready` is 1, `byte_ready` is 0, and no RAM write, claim or completion is issued.
- R2: A frame is discarded when reception is disabled, when soft reset is set, when no page is offered, or when its stored length exceeds 2048. A discarded frame's bytes are still accepted up to `byte_last`, but it makes no write, no claim and no completion.
- R3: Page byte 0 is 0x00. Page byte 1 has bit 4 (0x10) set for an odd frame length and bit 3 (0x08) set for a length above 1518. Together they form a little-endian status word with bits 0x1000 and 0x0800.
- R4: Page bytes 2 and 3 hold the stored length, low byte first. The stored length is the frame length rounded down to even (64 if the frame is shorter than 64), plus 6, plus 4 when `cfg_strip_crc` is 0.
- R5: Payload bytes start at page byte 4, in arrival order. Frames shorter than 64 bytes keep every byte in line (an odd last byte included) and are zero-padded to 64 payload bytes. Longer frames store their even-rounded length here.
- R6: When `cfg_strip_crc` is 0, the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion) follows the payload, least significant byte first. It is taken over all frame bytes for frames of 64 bytes or more, and over the 64 padded bytes for shorter frames.
- R7: The last two stored bytes form the trailer. For an odd frame of 64 bytes or more, they are the frame's last byte followed by 0x60. Otherwise they are 0x00 followed by 0x40.
- R8: A kept frame makes exactly one `pg_claim` pulse at acceptance and one single-cycle `done` pulse after its last write. Every write and `done_page` carry the claimed page number.
- R9: From acceptance or discard of a descriptor until the frame is finished, `frm_ready` is 0. `byte_ready` is 1 only while frame bytes are being taken, never during header writes.
- R10: A kept frame writes exactly stored-length bytes, each page address below the stored length exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Reception enabled |
| cfg_soft_rst | input | 1 | Controller soft reset active (frames discarded) |
| cfg_strip_crc | input | 1 | 1: do not store the CRC |
| pg_avail | input | 1 | Allocator offers a free page |
| pg_num | input | PG_W | Number of the offered page |
| pg_claim | output | 1 | Offered page taken for this frame |
| frm_start | input | 1 | Frame descriptor valid |
| frm_len | input | LEN_W | Frame length in bytes (at least 1) |
| frm_ready | output | 1 | Descriptor accepted this cycle if valid |
| byte_valid | input | 1 | Frame byte valid |
| byte_data | input | 8 | Frame byte |
| byte_last | input | 1 | Marks the final frame byte |
| byte_ready | output | 1 | Frame byte accepted this cycle if valid |
| wr_en | output | 1 | RAM byte write |
| wr_page | output | PG_W | Page of the write |
| wr_addr | output | ADDR_W | Byte offset within the page |
| wr_data | output | 8 | Byte written |
| done | output | 1 | Frame completely stored |
| done_page | output | PG_W | Page of the completed frame |

## Verification
The bench uses the default build: four pages of 2048 bytes, 12-bit frame lengths, a 64-byte minimum and a 1518-byte long-frame limit. The 12-bit length reaches beyond the page size. This lets the frames just inside and just outside the 2048-byte stored-length limit be tried both with and without the CRC. The 1518 threshold lies inside the accepted range, so the long-frame status bit is seen on frames that are stored. Short frames, both odd and even, exercise in-line odd bytes and zero padding. Long odd frames exercise the CRC-before-odd-byte trailer.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_DATA,
        S_DRAIN,
        S_PAD,
        S_CRC,
        S_TAIL,
        S_DONE
    } rxf_state_e;

    typedef struct packed {
        logic keep_crc;
        logic odd;
        logic long_frm;
        logic tail_odd;
    } rxf_flags_t;

    localparam int HDR_BYTES  = 4;
    localparam int CRC_BYTES  = 4;
    localparam int TAIL_BYTES = 2;
    localparam int OVERHEAD   = HDR_BYTES + TAIL_BYTES;

    localparam logic [7:0]  STAT_HI_ODD    = 8'h10;
    localparam logic [7:0]  STAT_HI_LONG   = 8'h08;
    localparam logic [7:0]  MARK_ODD       = 8'h60;
    localparam logic [7:0]  MARK_EVEN      = 8'h40;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c,
                                               input logic [7:0]  d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    import rxf_pkg::*;

    logic [31:0] state;

    always_ff @(posedge clk) begin
        if (rst || clear)  state <= '1;
        else if (feed)     state <= crc32_byte(state, din);
    end

    assign crc_out = ~state;

endmodule

// File: rtl/rxf_seq.sv
module rxf_seq #(
    parameter int PG_W       = 2,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int ADDR_W     = 11,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_soft_rst,
    input  logic              cfg_strip_crc,
    input  logic              pg_avail,
    input  logic [PG_W-1:0]   pg_num,
    output logic              pg_claim,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_ready,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    output logic              wr_en,
    output logic [PG_W-1:0]   wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [PG_W-1:0]   done_page,
    input  logic [31:0]       crc_val,
    output logic              crc_clear,
    output logic              crc_feed,
    output logic [7:0]        crc_din
);
    import rxf_pkg::*;

    localparam logic [ADDR_W-1:0] MIN_A      = ADDR_W'(MIN_FRAME);
    localparam logic [ADDR_W-1:0] MIN_LAST_A = ADDR_W'(MIN_FRAME - 1);
    localparam logic [ADDR_W-1:0] HDR_A      = ADDR_W'(HDR_BYTES);
    localparam logic [ADDR_W-1:0] CRC_A      = ADDR_W'(CRC_BYTES);

    rxf_state_e        st, nxt;
    logic [1:0]        cnt, cnt_n;
    logic [ADDR_W-1:0] pidx, pidx_n;
    rxf_flags_t        flags;
    logic [15:0]       stored_r;
    logic [PG_W-1:0]   page_r;
    logic [7:0]        held;

    // descriptor evaluation
    logic [15:0] len16, body, stored_c;
    logic        short_c, fits_c, accept_c;
    rxf_flags_t  flags_c;

    always_comb begin
        len16    = 16'(frm_len);
        short_c  = len16 < 16'(MIN_FRAME);
        body     = short_c ? 16'(MIN_FRAME) : (len16 & ~16'd1);
        stored_c = body + 16'(OVERHEAD) + (cfg_strip_crc ? 16'd0 : 16'(CRC_BYTES));
        fits_c   = stored_c <= 16'(PAGE_BYTES);
        accept_c = cfg_rx_en && !cfg_soft_rst && pg_avail && fits_c;
        flags_c.keep_crc = !cfg_strip_crc;
        flags_c.odd      = frm_len[0];
        flags_c.long_frm = len16 > 16'(MAX_FRAME);
        flags_c.tail_odd = frm_len[0] && !short_c;
    end

    logic [ADDR_W-1:0] base;
    logic              hold_last;
    assign base      = HDR_A + pidx;
    assign hold_last = byte_last && flags.tail_odd;

    always_comb begin
        nxt       = st;
        cnt_n     = cnt;
        pidx_n    = pidx;
        wr_en     = 1'b0;
        wr_addr   = base;
        wr_data   = 8'h00;
        crc_feed  = 1'b0;
        crc_din   = byte_data;
        pg_claim  = 1'b0;
        done      = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (frm_start) begin
                    if (accept_c) begin
                        pg_claim = 1'b1;
                        nxt      = S_HEAD;
                    end else begin
                        nxt = S_DRAIN;
                    end
                end
            end
            S_HEAD: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(cnt);
                unique case (cnt)
                    2'd0: wr_data = 8'h00;
                    2'd1: wr_data = (flags.odd ? STAT_HI_ODD : 8'h00) |
                                    (flags.long_frm ? STAT_HI_LONG : 8'h00);
                    2'd2: wr_data = stored_r[7:0];
                    default: wr_data = stored_r[15:8];
                endcase
                cnt_n = cnt + 2'd1;
                if (cnt == 2'd3) nxt = S_DATA;
            end
            S_DATA: begin
                if (byte_valid) begin
                    crc_feed = 1'b1;
                    if (!hold_last) begin
                        wr_en   = 1'b1;
                        wr_data = byte_data;
                        pidx_n  = pidx + 1'b1;
                    end
                    if (byte_last) begin
                        if (pidx_n < MIN_A)       nxt = S_PAD;
                        else if (flags.keep_crc)  nxt = S_CRC;
                        else                      nxt = S_TAIL;
                    end
                end
            end
            S_DRAIN: begin
                if (byte_valid && byte_last) nxt = S_IDLE;
            end
            S_PAD: begin
                wr_en    = 1'b1;
                crc_feed = 1'b1;
                crc_din  = 8'h00;
                pidx_n   = pidx + 1'b1;
                if (pidx == MIN_LAST_A) nxt = flags.keep_crc ? S_CRC : S_TAIL;
            end
            S_CRC: begin
                wr_en   = 1'b1;
                wr_addr = base + ADDR_W'(cnt);
                wr_data = crc_val[{cnt, 3'b000} +: 8];
                cnt_n   = cnt + 2'd1;
                if (cnt == 2'd3) nxt = S_TAIL;
            end
            S_TAIL: begin
                wr_en   = 1'b1;
                wr_addr = base + (flags.keep_crc ? CRC_A : '0) + ADDR_W'(cnt);
                if (cnt == 2'd0) wr_data = flags.tail_odd ? held : 8'h00;
                else             wr_data = flags.tail_odd ? MARK_ODD : MARK_EVEN;
                cnt_n = cnt + 2'd1;
                if (cnt == 2'd1) begin
                    cnt_n = 2'd0;
                    nxt   = S_DONE;
                end
            end
            default: begin
                done = 1'b1;
                nxt  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cnt      <= '0;
            pidx     <= '0;
            flags    <= '0;
            stored_r <= '0;
            page_r   <= '0;
            held     <= '0;
        end else begin
            st   <= nxt;
            cnt  <= cnt_n;
            pidx <= pidx_n;
            if (st == S_IDLE && frm_start) begin
                flags    <= flags_c;
                stored_r <= stored_c;
                page_r   <= pg_num;
                pidx     <= '0;
                cnt      <= '0;
            end
            if (st == S_DATA && byte_valid && byte_last) held <= byte_data;
        end
    end

    assign crc_clear  = pg_claim;
    assign frm_ready  = (st == S_IDLE);
    assign byte_ready = (st == S_DATA) || (st == S_DRAIN);
    assign wr_page    = page_r;
    assign done_page  = page_r;

endmodule

// File: rtl/rxf_formatter.sv
module rxf_formatter #(
    parameter int PG_W       = 2,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_soft_rst,
    input  logic              cfg_strip_crc,
    input  logic              pg_avail,
    input  logic [PG_W-1:0]   pg_num,
    output logic              pg_claim,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_ready,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    output logic              wr_en,
    output logic [PG_W-1:0]   wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [PG_W-1:0]   done_page
);

    logic [31:0] crc_val;
    logic        crc_clear, crc_feed;
    logic [7:0]  crc_din;

    rxf_seq #(
        .PG_W(PG_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst), .cfg_strip_crc(cfg_strip_crc),
        .pg_avail(pg_avail), .pg_num(pg_num), .pg_claim(pg_claim),
        .frm_start(frm_start), .frm_len(frm_len), .frm_ready(frm_ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .byte_ready(byte_ready),
        .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .done_page(done_page),
        .crc_val(crc_val), .crc_clear(crc_clear), .crc_feed(crc_feed), .crc_din(crc_din)
    );

    rxf_crc32 u_crc (
        .clk(clk), .rst(rst), .clear(crc_clear), .feed(crc_feed),
        .din(crc_din), .crc_out(crc_val)
    );

endmodule

// File: rtl/rxf_formatter_chk.sv
module rxf_formatter_chk #(
    parameter int PG_W   = 2,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_rx_en,
    input logic              cfg_soft_rst,
    input logic              pg_avail,
    input logic [PG_W-1:0]   pg_num,
    input logic              pg_claim,
    input logic              frm_start,
    input logic              frm_ready,
    input logic              byte_ready,
    input logic              wr_en,
    input logic [PG_W-1:0]   wr_page,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_en && !done && !byte_ready));  // R1

    AST_CLAIM_GATED: assert property (@(posedge clk) disable iff (rst)
        pg_claim |-> (cfg_rx_en && !cfg_soft_rst && pg_avail && frm_start && frm_ready));  // R2

    AST_HEAD_AFTER_CLAIM: assert property (@(posedge clk) disable iff (rst)
        pg_claim |=> (wr_en && wr_addr == '0 && wr_page == $past(pg_num)));  // R3

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_page == $past(wr_page)));  // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        frm_ready |-> !wr_en);  // R9

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(frm_ready && byte_ready));  // R9

endmodule

bind rxf_formatter rxf_formatter_chk #(.PG_W(PG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
    .pg_avail(pg_avail), .pg_num(pg_num), .pg_claim(pg_claim),
    .frm_start(frm_start), .frm_ready(frm_ready), .byte_ready(byte_ready),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .done(done)
);

// File: tb/test_rxf_formatter.sv
module test_rxf_formatter;
    localparam int CLK_PERIOD = 10;
    localparam int PG_W       = 2;
    localparam int LEN_W      = 12;
    localparam int PAGE_BYTES = 2048;
    localparam int ADDR_W     = 11;

    logic clk = 1'b0;
    logic rst;
    logic cfg_rx_en, cfg_soft_rst, cfg_strip_crc, pg_avail;
    logic [PG_W-1:0] pg_num;
    logic pg_claim, frm_start, frm_ready;
    logic [LEN_W-1:0] frm_len;
    logic byte_valid, byte_last, byte_ready;
    logic [7:0] byte_data;
    logic wr_en;
    logic [PG_W-1:0] wr_page, done_page;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;
    logic done;

    rxf_formatter #(.PG_W(PG_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) i_rxf_formatter (
        .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
        .cfg_strip_crc(cfg_strip_crc), .pg_avail(pg_avail), .pg_num(pg_num),
        .pg_claim(pg_claim), .frm_start(frm_start), .frm_len(frm_len),
        .frm_ready(frm_ready), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_last(byte_last), .byte_ready(byte_ready), .wr_en(wr_en),
        .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .done_page(done_page)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int fid  = 0;
    logic [7:0] frame   [0:4095];
    logic [7:0] exp_img [0:PAGE_BYTES-1];
    logic [7:0] mem     [0:PAGE_BYTES-1];
    int         stamp   [0:PAGE_BYTES-1];
    int wr_total = 0, dup_total = 0, done_total = 0, claim_total = 0, pgerr_total = 0;
    logic [PG_W-1:0] cur_pg = '0;
    logic [PG_W-1:0] last_done_pg = '0;

    initial for (int a = 0; a < PAGE_BYTES; a++) stamp[a] = 0;

    // write monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                mem[wr_addr]   <= wr_data;
                stamp[wr_addr] <= fid;
                wr_total       <= wr_total + 1;
                if (stamp[wr_addr] == fid) dup_total <= dup_total + 1;
                if (wr_page != cur_pg) pgerr_total <= pgerr_total + 1;
            end
            if (done) begin
                done_total   <= done_total + 1;
                last_done_pg <= done_page;
            end
            if (pg_claim) claim_total <= claim_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input int lo, input int hi, input string req);
        int bad = 0;
        int fa = 0;
        int fe = 0;
        for (int a = lo; a < hi; a++) begin
            int act;
            act = (stamp[a] == fid) ? int'(mem[a]) : -1;
            if (act != int'(exp_img[a])) begin
                if (bad == 0) begin fa = act; fe = int'(exp_img[a]); end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    function automatic logic [31:0] ref_crc(input int n, input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (i < len) ? frame[i] : 8'h00;
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        return ~c;
    endfunction

    function automatic int body_len(input int len);
        return (len < 64) ? 64 : (len & ~1);
    endfunction

    function automatic int stored_len(input int len, input bit strip);
        return body_len(len) + 6 + (strip ? 0 : 4);
    endfunction

    task automatic run_frame(input int len, input bit strip, input bit en, input bit srst,
                             input bit avail, input int pg, input bit gaps);
        int w0, c0, d0, dup0, pe0, sl, body, crc_at, tail_at;
        bit keep;
        logic [31:0] crc;
        for (int i = 0; i < len; i++) frame[i] = 8'($urandom);
        @(negedge clk);
        fid++;
        cur_pg = PG_W'(pg);
        w0 = wr_total; c0 = claim_total; d0 = done_total; dup0 = dup_total; pe0 = pgerr_total;
        sl   = stored_len(len, strip);
        body = body_len(len);
        keep = en && !srst && avail && (sl <= PAGE_BYTES);
        cfg_rx_en = en; cfg_soft_rst = srst; cfg_strip_crc = strip;
        pg_avail = avail; pg_num = PG_W'(pg);
        frm_len = LEN_W'(len); frm_start = 1'b1;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        frm_start = 1'b0;
        chk(frm_ready == 1'b0, "R9 busy after descriptor", frm_ready, 0);
        if (keep) chk(byte_ready == 1'b0, "R9 no bytes during header", byte_ready, 0);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
            byte_valid = 1'b1; byte_data = frame[i]; byte_last = (i == len - 1);
            while (!byte_ready) @(negedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b0; byte_last = 1'b0;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) begin
            chk((wr_total - w0) == 0 && (claim_total - c0) == 0 && (done_total - d0) == 0,
                "R2 discarded frame left no trace", wr_total - w0 + claim_total - c0 + done_total - d0, 0);
            return;
        end
        // expected page image
        exp_img[0] = 8'h00;
        exp_img[1] = ((len % 2 == 1) ? 8'h10 : 8'h00) | ((len > 1518) ? 8'h08 : 8'h00);
        exp_img[2] = 8'(sl);
        exp_img[3] = 8'(sl >> 8);
        for (int i = 0; i < body; i++) exp_img[4 + i] = (i < len) ? frame[i] : 8'h00;
        crc_at  = 4 + body;
        tail_at = crc_at + (strip ? 0 : 4);
        crc = ref_crc((len < 64) ? 64 : len, len);
        if (!strip) for (int k = 0; k < 4; k++) exp_img[crc_at + k] = crc[8*k +: 8];
        if (len >= 64 && (len % 2 == 1)) begin
            exp_img[tail_at] = frame[len - 1]; exp_img[tail_at + 1] = 8'h60;
        end else begin
            exp_img[tail_at] = 8'h00; exp_img[tail_at + 1] = 8'h40;
        end
        chk_range(0, 2, "R3 status word");
        chk_range(2, 4, "R4 stored length");
        chk_range(4, crc_at, "R5 payload and padding");
        if (!strip) chk_range(crc_at, tail_at, "R6 crc bytes");
        chk_range(tail_at, tail_at + 2, "R7 trailer");
        chk((wr_total - w0) == sl && (dup_total - dup0) == 0, "R10 write footprint",
            wr_total - w0, sl);
        chk((claim_total - c0) == 1 && (done_total - d0) == 1 && last_done_pg == PG_W'(pg)
            && (pgerr_total - pe0) == 0, "R8 claim/done/page",
            int'(last_done_pg), pg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        cfg_rx_en = 1'b0; cfg_soft_rst = 1'b0; cfg_strip_crc = 1'b0;
        pg_avail = 1'b0; pg_num = '0; frm_start = 1'b0; frm_len = '0;
        byte_valid = 1'b0; byte_last = 1'b0; byte_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(frm_ready == 1'b1 && byte_ready == 1'b0 && wr_en == 1'b0 && done == 1'b0,
            "R1 idle after reset", {frm_ready, byte_ready, wr_en, done}, 4'b1000);

        // directed corners: len, strip, en, srst, avail, page, gaps
        run_frame(1,    0, 1, 0, 1, 0, 0);  // R5 short odd, R7 even-style trailer
        run_frame(2,    1, 1, 0, 1, 1, 0);
        run_frame(63,   0, 1, 0, 1, 2, 1);
        run_frame(64,   0, 1, 0, 1, 3, 0);
        run_frame(65,   0, 1, 0, 1, 1, 0);  // R7 long odd trailer
        run_frame(101,  1, 1, 0, 1, 2, 1);
        run_frame(1518, 0, 1, 0, 1, 0, 0);
        run_frame(1519, 0, 1, 0, 1, 3, 0);  // R3 long bit
        run_frame(2039, 0, 1, 0, 1, 1, 0);  // R4 fits exactly
        run_frame(2040, 0, 1, 0, 1, 1, 0);  // R2 too long with crc
        run_frame(2043, 1, 1, 0, 1, 2, 0);
        run_frame(2044, 1, 1, 0, 1, 2, 0);  // R2 too long stripped
        run_frame(80,   0, 0, 0, 1, 0, 0);  // R2 disabled
        run_frame(80,   0, 1, 1, 1, 0, 0);  // R2 soft reset
        run_frame(80,   0, 1, 0, 0, 0, 1);  // R2 no page
        for (int r = 0; r < 25; r++) begin
            run_frame(1 + int'($urandom % 700), bit'($urandom % 2), ($urandom % 10) != 0,
                      1'b0, ($urandom % 8) != 0, int'($urandom % 4), 1'b1);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule